// File: doc/BRIEF.md
# Debug Trigger Comparator Bank

This block holds a small set of programmable debug triggers and checks every instruction fetch, load or store that the pipeline presents against them. Each trigger has a control word and a compare value. The control word holds the enables for operation and privilege, the choice of operand, the match mode, the chain flag and an action code. The compare value is the reference that the chosen operand is tested against. Software or a debug module loads both through a one-word register-write port.

Each trigger is filtered by its enables. It then compares either the access address or the access data using one of six modes: equality, naturally aligned power-of-two range, unsigned at-or-above, unsigned below, and two half-word masked compares. Adjacent triggers may be chained so that a group fires only when all of its members match. The lowest-index trigger that fires is reported one clock after the request, together with its action code. Whatever consumes the hit carries out the action. In debug mode the bank stays silent.

Top module: `dbg_trig_match`

## Requirements
- R1: After reset every control word and compare value is zero, so no trigger can fire. `hit` is 0, and whenever `hit` is 0 both `hit_idx` and `hit_action` are 0.
- R2: The result for a request with `req_valid` high appears on the outputs after the next rising clock edge. A cycle with `req_valid` low gives `hit` = 0 after that edge.
- R3: When `dbg_mode` is high with a request, `hit` is 0 after the edge, whatever the triggers hold.
- R4: A trigger takes part only when it is enabled for the operation and for the privilege. Control bit 5 enables execute (`req_op` 0), bit 4 store (1) and bit 3 load (2). Bit 2 enables M (`req_priv` 3), bit 1 S (1) and bit 0 U (0). `req_op` 3 and `req_priv` 2 never qualify.
- R5: Control bit 6 set selects `req_data` as the compared operand. Clear selects `req_addr`.
- R6: With `req_narrow` high the operand is cut to its low 32 bits before comparison, and the half width used by the mask modes is 16. With it low the half width is XLEN/2. The compare value is always used at full width.
- R7: Mode field bits 9:7. Mode 0 fires on operand == compare. Mode 2 fires on operand >= compare, unsigned. Mode 3 fires on operand < compare, unsigned.
- R8: Mode 1 counts the run of ones at the bottom of the compare value, ignores that many low bits of both operands, and fires when the rest are equal. An all-ones compare value fires on any operand.
- R9: Mode 4 uses the compare value shifted right by the half width as a mask, and fires when (operand & mask) == (compare & mask). Mode 5 uses the same mask but tests ((operand >> half) & mask) against (compare & mask).
- R10: Modes 6 and 7 never fire.
- R11: The lowest-index firing trigger is reported. `hit_action` is bits 15:12 of that trigger's control word.
- R12: Control bit 10 (chain) joins a trigger to the next one. A group ends at the first member whose chain bit is clear. It fires, reporting that last member, only when every member matches; one failing member silences the whole group. A chained last trigger never fires.
- R13: The write port loads the compare value (`wr_is_cmp` 1) or the low 16 bits as control word (`wr_is_cmp` 0) of trigger `wr_idx` at the clock edge. A request in the same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Trigger written |
| wr_is_cmp | input | 1 | 1 writes the compare value, 0 writes the control word |
| wr_data | input | XLEN | Write data |
| req_valid | input | 1 | An access is presented this cycle |
| req_op | input | 2 | 0 execute, 1 store, 2 load |
| req_priv | input | 2 | 0 U, 1 S, 3 M |
| req_addr | input | XLEN | Access address |
| req_data | input | XLEN | Access data |
| req_narrow | input | 1 | 32-bit operating width |
| dbg_mode | input | 1 | Hart is halted in debug mode |
| hit | output | 1 | A trigger fired on the previous request |
| hit_idx | output | IDX_W | Index of the reporting trigger |
| hit_action | output | 4 | Action code of the reporting trigger |

## Verification
The assertions assume that reset is applied before the first request, so the stored control words they compare against are known. They also assume that the write port and the request path are both driven for the whole cycle, so the registered control copy in the checker lines up with the words the bank used for the request. The stimulus drives all inputs on the falling edge. It writes random control words and compare values one at a time, and it draws addresses, data and compare values from a few shared upper halves, so that hits, near misses and chain groups occur often. Directed cases cover the mode boundaries, a write and a request in the same cycle, and the debug and disabled-operation cases.

// File: rtl/dtm_pkg.sv
`timescale 1ns/1ps
package dtm_pkg;
   localparam int CTRL_W = 16;
   localparam int ACT_W  = 4;

   typedef enum logic [2:0] {
      MD_EQ    = 3'd0,
      MD_NAPOT = 3'd1,
      MD_GE    = 3'd2,
      MD_LT    = 3'd3,
      MD_MLO   = 3'd4,
      MD_MHI   = 3'd5
   } trig_mode_e;

   typedef enum logic [1:0] {
      OP_EXEC  = 2'd0,
      OP_STORE = 2'd1,
      OP_LOAD  = 2'd2
   } trig_op_e;

   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   // control word, MSB first: action, spare, chain, mode, select, enables
   typedef struct packed {
      logic [ACT_W-1:0] action;
      logic             spare;
      logic             chain;
      logic [2:0]       mode;
      logic             sel_data;
      logic             en_ex;
      logic             en_st;
      logic             en_ld;
      logic             en_m;
      logic             en_s;
      logic             en_u;
   } trig_ctrl_t;
endpackage

// File: rtl/dtm_regs.sv
`timescale 1ns/1ps
module dtm_regs
   import dtm_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int NUM_TRIG = 4,
   parameter int IDX_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_is_cmp,
   input  logic [XLEN-1:0]  wr_data,
   output trig_ctrl_t       ctrl_o [NUM_TRIG],
   output logic [XLEN-1:0]  cmp_o  [NUM_TRIG]
);
   for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
      logic sel_me;
      assign sel_me = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ctrl_o[g] <= '0;
            cmp_o[g]  <= '0;
         end else if (sel_me) begin
            if (wr_is_cmp) cmp_o[g]  <= wr_data;
            else           ctrl_o[g] <= trig_ctrl_t'(wr_data[CTRL_W-1:0]);
         end
      end
   end
endmodule

// File: rtl/dtm_cmp.sv
`timescale 1ns/1ps
module dtm_cmp
   import dtm_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter bit HAS_NARROW = 1'b1
) (
   input  logic [5:0]      en_bits,
   input  logic            sel_data,
   input  logic [2:0]      mode,
   input  logic [XLEN-1:0] cmp,
   input  logic [1:0]      op,
   input  logic [1:0]      priv,
   input  logic [XLEN-1:0] addr,
   input  logic [XLEN-1:0] data,
   input  logic            narrow,
   output logic            match
);
   localparam int HALF = XLEN / 2;

   logic            op_ok, priv_ok, cmp_ok;
   logic [XLEN-1:0] raw_val, val, mask, hi_val, low_ign;

   // enable filters: en_bits = {ex, st, ld, m, s, u}
   always_comb begin
      unique case (op)
         OP_EXEC:  op_ok = en_bits[5];
         OP_STORE: op_ok = en_bits[4];
         OP_LOAD:  op_ok = en_bits[3];
         default:  op_ok = 1'b0;
      endcase
      unique case (priv)
         PRIV_M:  priv_ok = en_bits[2];
         PRIV_S:  priv_ok = en_bits[1];
         PRIV_U:  priv_ok = en_bits[0];
         default: priv_ok = 1'b0;
      endcase
   end

   assign raw_val = sel_data ? data : addr;

   if (HAS_NARROW) begin : g_narrow
      assign val    = narrow ? {{(XLEN-32){1'b0}}, raw_val[31:0]} : raw_val;
      assign mask   = narrow ? (cmp >> 16) : (cmp >> HALF);
      assign hi_val = narrow ? (val >> 16) : (val >> HALF);
   end else begin : g_wide
      logic unused_narrow;
      assign unused_narrow = narrow;
      assign val    = raw_val;
      assign mask   = cmp >> HALF;
      assign hi_val = val >> HALF;
   end

   // bits below the first zero of the compare value
   assign low_ign = cmp & ~(cmp + XLEN'(1));

   always_comb begin
      unique case (mode)
         MD_EQ:    cmp_ok = (val == cmp);
         MD_NAPOT: cmp_ok = (((val ^ cmp) & ~low_ign) == '0);
         MD_GE:    cmp_ok = (val >= cmp);
         MD_LT:    cmp_ok = (val < cmp);
         MD_MLO:   cmp_ok = ((val & mask) == (cmp & mask));
         MD_MHI:   cmp_ok = ((hi_val & mask) == (cmp & mask));
         default:  cmp_ok = 1'b0;
      endcase
   end

   assign match = op_ok && priv_ok && cmp_ok;
endmodule

// File: rtl/dtm_resolve.sv
`timescale 1ns/1ps
module dtm_resolve #(
   parameter int NUM_TRIG = 4,
   parameter int IDX_W    = 2
) (
   input  logic [NUM_TRIG-1:0] match,
   input  logic [NUM_TRIG-1:0] chain,
   output logic                hit,
   output logic [IDX_W-1:0]    idx
);
   logic grp_ok;

   always_comb begin
      grp_ok = 1'b1;
      hit    = 1'b0;
      idx    = '0;
      for (int i = 0; i < NUM_TRIG; i++) begin
         if (!hit && grp_ok && match[i] && !chain[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
         grp_ok = chain[i] ? (grp_ok & match[i]) : 1'b1;
      end
   end
endmodule

// File: rtl/dbg_trig_match.sv
`timescale 1ns/1ps
module dbg_trig_match
   import dtm_pkg::*;
#(
   parameter int  XLEN       = 64,
   parameter int  NUM_TRIG   = 4,
   parameter bit  HAS_NARROW = 1'b1,
   localparam int IDX_W      = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_is_cmp,
   input  logic [XLEN-1:0]  wr_data,
   input  logic             req_valid,
   input  logic [1:0]       req_op,
   input  logic [1:0]       req_priv,
   input  logic [XLEN-1:0]  req_addr,
   input  logic [XLEN-1:0]  req_data,
   input  logic             req_narrow,
   input  logic             dbg_mode,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx,
   output logic [ACT_W-1:0] hit_action
);
   if (XLEN < CTRL_W || (XLEN % 2) != 0) begin : g_bad_xlen
      $error("dbg_trig_match: XLEN must be even and at least CTRL_W");
   end
   if (HAS_NARROW && XLEN < 32) begin : g_bad_narrow
      $error("dbg_trig_match: narrow mode needs XLEN >= 32");
   end
   if (NUM_TRIG < 2 || NUM_TRIG > 16 || (1 << IDX_W) != NUM_TRIG) begin : g_bad_num
      $error("dbg_trig_match: NUM_TRIG must be a power of two in 2..16");
   end

   trig_ctrl_t                  ctrl [NUM_TRIG];
   logic [XLEN-1:0]             cmpv [NUM_TRIG];
   logic [NUM_TRIG-1:0]         match_v, chain_v, spare_v;
   logic [NUM_TRIG*CTRL_W-1:0]  ctrl_flat;
   logic                        res_hit;
   logic [IDX_W-1:0]            res_idx;
   logic                        unused_spare;

   dtm_regs #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_is_cmp (wr_is_cmp),
      .wr_data   (wr_data),
      .ctrl_o    (ctrl),
      .cmp_o     (cmpv)
   );

   for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
      dtm_cmp #(.XLEN(XLEN), .HAS_NARROW(HAS_NARROW)) u_cmp (
         .en_bits  ({ctrl[g].en_ex, ctrl[g].en_st, ctrl[g].en_ld,
                     ctrl[g].en_m,  ctrl[g].en_s,  ctrl[g].en_u}),
         .sel_data (ctrl[g].sel_data),
         .mode     (ctrl[g].mode),
         .cmp      (cmpv[g]),
         .op       (req_op),
         .priv     (req_priv),
         .addr     (req_addr),
         .data     (req_data),
         .narrow   (req_narrow),
         .match    (match_v[g])
      );
      assign chain_v[g] = ctrl[g].chain;
      assign spare_v[g] = ctrl[g].spare;
      assign ctrl_flat[g*CTRL_W +: CTRL_W] = ctrl[g];
   end

   assign unused_spare = |spare_v;

   dtm_resolve #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) u_resolve (
      .match (match_v),
      .chain (chain_v),
      .hit   (res_hit),
      .idx   (res_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit        <= 1'b0;
         hit_idx    <= '0;
         hit_action <= '0;
      end else if (req_valid && !dbg_mode && res_hit) begin
         hit        <= 1'b1;
         hit_idx    <= res_idx;
         hit_action <= ctrl[res_idx].action;
      end else begin
         hit        <= 1'b0;
         hit_idx    <= '0;
         hit_action <= '0;
      end
   end
endmodule

// File: rtl/dtm_check.sv
`timescale 1ns/1ps
module dtm_check
   import dtm_pkg::*;
#(
   parameter int NUM_TRIG = 4,
   parameter int IDX_W    = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       req_valid,
   input logic [1:0]                 req_op,
   input logic [1:0]                 req_priv,
   input logic                       dbg_mode,
   input logic                       hit,
   input logic [IDX_W-1:0]           hit_idx,
   input logic [ACT_W-1:0]           hit_action,
   input logic [NUM_TRIG*CTRL_W-1:0] ctrl_flat
);
   logic [NUM_TRIG*CTRL_W-1:0] ctrl_q;
   logic                       any_ex;
   trig_ctrl_t                 rep_ctrl;

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_flat;
   end

   always_comb begin
      any_ex = 1'b0;
      for (int i = 0; i < NUM_TRIG; i++) begin
         any_ex = any_ex | ctrl_flat[i*CTRL_W + 5];
      end
   end

   assign rep_ctrl = trig_ctrl_t'(ctrl_q[hit_idx*CTRL_W +: CTRL_W]);

   AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (hit_idx == '0 && hit_action == '0)); // R1

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !hit); // R2

   AST_DEBUG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && dbg_mode) |=> !hit); // R3

   AST_EXEC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_EXEC && !any_ex) |=> !hit); // R4

   AST_PRIV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_priv == 2'd2) |=> !hit); // R4

   AST_ACTION_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> hit_action == rep_ctrl.action); // R11

   AST_GROUP_END: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> !rep_ctrl.chain); // R12
endmodule

bind dbg_trig_match dtm_check #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_op     (req_op),
   .req_priv   (req_priv),
   .dbg_mode   (dbg_mode),
   .hit        (hit),
   .hit_idx    (hit_idx),
   .hit_action (hit_action),
   .ctrl_flat  (ctrl_flat)
);

// File: tb/dbg_trig_match_test.sv
`timescale 1ns/1ps
module dbg_trig_match_test;
   localparam int XL = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_idx = '0;
   logic        wr_is_cmp = 1'b0;
   logic [63:0] wr_data = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = '0;
   logic [1:0]  req_priv = '0;
   logic [63:0] req_addr = '0;
   logic [63:0] req_data = '0;
   logic        req_narrow = 1'b0;
   logic        dbg_mode = 1'b0;
   logic        hit;
   logic [1:0]  hit_idx;
   logic [3:0]  hit_action;

   int vec_cnt = 0;
   int bad_cnt = 0;

   logic [15:0] sh_ctrl [4];
   logic [63:0] sh_cmp  [4];

   always #5 clk = ~clk;

   dbg_trig_match uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_is_cmp(wr_is_cmp), .wr_data(wr_data), .req_valid(req_valid),
      .req_op(req_op), .req_priv(req_priv), .req_addr(req_addr),
      .req_data(req_data), .req_narrow(req_narrow), .dbg_mode(dbg_mode),
      .hit(hit), .hit_idx(hit_idx), .hit_action(hit_action)
   );

   // control word helper: {action, chain, mode, sel, ex, st, ld, m, s, u}
   function automatic logic [15:0] mk(input logic [3:0] act, input bit ch,
                                      input logic [2:0] md, input bit sel,
                                      input logic [5:0] en);
      return {act, 1'b0, ch, md, sel, en};
   endfunction

   function automatic bit trig_fires(input int i, input logic [1:0] op,
                                     input logic [1:0] pr, input logic [63:0] a,
                                     input logic [63:0] d, input bit nar);
      logic [15:0] c;
      logic [63:0] v, t, m, ign;
      int half, ones;
      bit en_ok;
      c = sh_ctrl[i];
      t = sh_cmp[i];
      case (op)
         2'd0: en_ok = c[5];
         2'd1: en_ok = c[4];
         2'd2: en_ok = c[3];
         default: en_ok = 0;
      endcase
      case (pr)
         2'd0: en_ok = en_ok & c[0];
         2'd1: en_ok = en_ok & c[1];
         2'd3: en_ok = en_ok & c[2];
         default: en_ok = 0;
      endcase
      if (!en_ok) return 0;
      v = c[6] ? d : a;
      if (nar) v = v & 64'hFFFF_FFFF;
      half = nar ? 16 : 32;
      m = t >> half;
      case (c[9:7])
         3'd0: return v == t;
         3'd1: begin
            ones = 0;
            while (ones < 64 && t[ones]) ones++;
            ign = (ones == 64) ? '1 : ((64'd1 << ones) - 64'd1);
            return (v & ~ign) == (t & ~ign);
         end
         3'd2: return v >= t;
         3'd3: return v < t;
         3'd4: return (v & m) == (t & m);
         3'd5: return ((v >> half) & m) == (t & m);
         default: return 0;
      endcase
   endfunction

   task automatic expect_of(input logic [1:0] op, input logic [1:0] pr,
                            input logic [63:0] a, input logic [63:0] d,
                            input bit nar, input bit dbg, output bit eh,
                            output logic [1:0] ei, output logic [3:0] ea);
      eh = 0; ei = '0; ea = '0;
      if (dbg) return;
      for (int i = 0; i < 4; i++) begin
         int s;
         bit all;
         if (sh_ctrl[i][10]) continue;
         s = i;
         while (s > 0 && sh_ctrl[s-1][10]) s--;
         all = 1;
         for (int j = s; j <= i; j++) all = all & trig_fires(j, op, pr, a, d, nar);
         if (all) begin
            eh = 1; ei = 2'(i); ea = sh_ctrl[i][15:12];
            return;
         end
      end
   endtask

   task automatic check_out(input bit eh, input logic [1:0] ei,
                            input logic [3:0] ea, input string tag);
      vec_cnt++;
      if (hit !== eh || hit_idx !== ei || hit_action !== ea) begin
         bad_cnt++;
         $display("FAIL %s: got hit=%0b idx=%0d act=%0h, expected hit=%0b idx=%0d act=%0h",
                  tag, hit, hit_idx, hit_action, eh, ei, ea);
      end
   endtask

   task automatic wr(input int i, input bit is_cmp, input logic [63:0] v);
      wr_en = 1; wr_idx = 2'(i); wr_is_cmp = is_cmp; wr_data = v;
      @(negedge clk);
      wr_en = 0;
      if (is_cmp) sh_cmp[i] = v; else sh_ctrl[i] = v[15:0];
   endtask

   task automatic req(input logic [1:0] op, input logic [1:0] pr,
                      input logic [63:0] a, input logic [63:0] d,
                      input bit nar, input bit dbg, input string tag);
      bit eh; logic [1:0] ei; logic [3:0] ea;
      expect_of(op, pr, a, d, nar, dbg, eh, ei, ea);
      req_valid = 1; req_op = op; req_priv = pr; req_addr = a;
      req_data = d; req_narrow = nar; dbg_mode = dbg;
      @(negedge clk);
      req_valid = 0; dbg_mode = 0;
      check_out(eh, ei, ea, tag);
   endtask

   task automatic clear_all();
      for (int i = 0; i < 4; i++) begin
         wr(i, 0, 64'd0);
         wr(i, 1, 64'd0);
      end
   endtask

   localparam logic [5:0] ALL_EN = 6'b111111;

   initial begin
      #(200000 * 10);
      bad_cnt++;
      $display("FAIL R2: watchdog expired, got no end, expected end of run");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
   end

   initial begin
      bit eh; logic [1:0] ei; logic [3:0] ea;
      void'($urandom(32'd2024));
      for (int i = 0; i < 4; i++) begin sh_ctrl[i] = '0; sh_cmp[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state, then an all-zero bank ignores a matching access
      check_out(0, 0, 0, "R1 reset outputs");
      req(0, 3, 64'd0, 64'd0, 0, 0, "R1 zeroed bank");

      // R2: no request gives no hit even when trigger 0 would match
      wr(0, 0, 64'(mk(4'h3, 0, 3'd0, 0, ALL_EN)));
      wr(0, 1, 64'h100);
      req_addr = 64'h100; req_op = 0; req_priv = 3;
      @(negedge clk);
      check_out(0, 0, 0, "R2 idle cycle");
      req(0, 3, 64'h100, 0, 0, 0, "R2 one-cycle result");
      // R3
      req(0, 3, 64'h100, 0, 0, 1, "R3 debug mode");
      // R13: write and request together use old compare value
      wr_en = 1; wr_idx = 0; wr_is_cmp = 1; wr_data = 64'h200;
      expect_of(0, 3, 64'h100, 0, 0, 0, eh, ei, ea);
      req_valid = 1; req_op = 0; req_priv = 3; req_addr = 64'h100;
      @(negedge clk);
      wr_en = 0; req_valid = 0; sh_cmp[0] = 64'h200;
      check_out(eh, ei, ea, "R13 same-cycle write");
      req(0, 3, 64'h100, 0, 0, 0, "R13 old value gone");
      req(0, 3, 64'h200, 0, 0, 0, "R13 new value used");

      // R4: execute-only, M-only trigger
      wr(0, 0, 64'(mk(4'h1, 0, 3'd0, 0, 6'b100100)));
      req(2, 3, 64'h200, 0, 0, 0, "R4 load filtered");
      req(1, 3, 64'h200, 0, 0, 0, "R4 store filtered");
      req(0, 0, 64'h200, 0, 0, 0, "R4 user filtered");
      req(0, 2, 64'h200, 0, 0, 0, "R4 reserved privilege");
      req(0, 3, 64'h200, 0, 0, 0, "R4 qualified");
      // R5: select data
      wr(0, 0, 64'(mk(4'h2, 0, 3'd0, 1, ALL_EN)));
      req(2, 1, 64'h200, 64'h999, 0, 0, "R5 data compared");
      req(2, 1, 64'h999, 64'h200, 0, 0, "R5 data selected");
      // R6: narrow truncation
      wr(0, 0, 64'(mk(4'h2, 0, 3'd0, 0, ALL_EN)));
      wr(0, 1, 64'h1234_5678);
      req(0, 3, 64'hABCD_0000_1234_5678, 0, 1, 0, "R6 narrow hit");
      req(0, 3, 64'hABCD_0000_1234_5678, 0, 0, 0, "R6 wide miss");
      // R7: boundaries
      wr(0, 0, 64'(mk(4'h4, 0, 3'd2, 0, ALL_EN)));
      wr(0, 1, 64'h8000);
      req(0, 3, 64'h8000, 0, 0, 0, "R7 GE at equal");
      req(0, 3, 64'h7FFF, 0, 0, 0, "R7 GE below");
      wr(0, 0, 64'(mk(4'h4, 0, 3'd3, 0, ALL_EN)));
      req(0, 3, 64'h8000, 0, 0, 0, "R7 LT at equal");
      req(0, 3, 64'h7FFF, 0, 0, 0, "R7 LT below");
      // R8: NAPOT
      wr(0, 0, 64'(mk(4'h5, 0, 3'd1, 0, ALL_EN)));
      wr(0, 1, 64'h10F);
      req(0, 3, 64'h100, 0, 0, 0, "R8 range low");
      req(0, 3, 64'h10F, 0, 0, 0, "R8 range high");
      req(0, 3, 64'h110, 0, 0, 0, "R8 above range");
      wr(0, 1, '1);
      req(0, 3, 64'hDEAD_BEEF_0000_0001, 0, 0, 0, "R8 all ones");
      // R9: mask modes
      wr(0, 0, 64'(mk(4'h6, 0, 3'd4, 0, ALL_EN)));
      wr(0, 1, 64'h0000_00FF_0000_0034);
      req(0, 3, 64'h5555_0034, 0, 0, 0, "R9 mask low hit");
      req(0, 3, 64'h5555_0035, 0, 0, 0, "R9 mask low miss");
      wr(0, 0, 64'(mk(4'h6, 0, 3'd5, 0, ALL_EN)));
      req(0, 3, 64'h0000_1234_0000_0000, 0, 0, 0, "R9 mask high hit");
      req(0, 3, 64'h0000_0034_0000_0000, 0, 0, 0, "R9 mask high exact");
      req(0, 3, 64'h0034_0000, 0, 1, 0, "R9 narrow mask high");
      // R10
      wr(0, 1, '1);
      wr(0, 0, 64'(mk(4'h7, 0, 3'd6, 0, ALL_EN)));
      req(0, 3, 64'hFFFF, 0, 0, 0, "R10 mode 6");
      wr(0, 0, 64'(mk(4'h7, 0, 3'd7, 0, ALL_EN)));
      req(0, 3, 64'h0, 0, 0, 0, "R10 mode 7");
      // R11: priority
      clear_all();
      wr(1, 0, 64'(mk(4'h9, 0, 3'd2, 0, ALL_EN)));
      wr(2, 0, 64'(mk(4'hA, 0, 3'd2, 0, ALL_EN)));
      req(1, 1, 64'h40, 0, 0, 0, "R11 lowest index");
      // R12: chains
      wr(0, 0, 64'(mk(4'h1, 1, 3'd0, 0, ALL_EN)));
      wr(0, 1, 64'h40);
      req(1, 1, 64'h40, 0, 0, 0, "R12 group both match");
      req(1, 1, 64'h41, 0, 0, 0, "R12 failing head silences group");
      wr(3, 0, 64'(mk(4'hC, 1, 3'd2, 0, ALL_EN)));
      wr(1, 0, 64'(mk(4'h9, 0, 3'd6, 0, ALL_EN)));
      wr(2, 0, 64'(mk(4'hA, 0, 3'd6, 0, ALL_EN)));
      req(1, 1, 64'h40, 0, 0, 0, "R12 chained last trigger");

      // random mix, checked against the model (R7 to R12)
      for (int n = 0; n < 4000; n++) begin
         logic [63:0] hi_pool [4];
         logic [63:0] a, d, cv;
         logic [15:0] cw;
         int t;
         hi_pool[0] = 64'h0; hi_pool[1] = 64'hFFFF_FFFF;
         hi_pool[2] = 64'h0000_00FF; hi_pool[3] = 64'h8000_0001;
         t = $urandom % 4;
         if ($urandom % 2) begin
            cw = 16'($urandom);
            cw[5:0] = cw[5:0] | 6'(($urandom % 2) ? 6'b111111 : 6'b0);
            cw[10] = (($urandom % 3) == 0);
            wr(t, 0, 64'(cw));
         end else begin
            cv = {hi_pool[$urandom % 4][31:0], 24'h0, 8'($urandom % 16)};
            if ($urandom % 4 == 0) cv = cv | 64'h0F;
            wr(t, 1, cv);
         end
         a = {hi_pool[$urandom % 4][31:0], 24'h0, 8'($urandom % 16)};
         d = {hi_pool[$urandom % 4][31:0], 24'h0, 8'($urandom % 16)};
         req(2'($urandom % 4), 2'($urandom % 4), a, d, 1'($urandom % 2),
             (($urandom % 16) == 0), "R11 random model");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
   end
endmodule